// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides whether the processor core stays active or drops into one of three reduced-activity states, and it decides when the core resumes. The CPU sends a one-cycle pulse when it executes its idle instruction. On that cycle the block samples two control bits. The first is a power-down request and the second is a halt-versus-standby select. From these the block picks a plain IDLE state, a STANDBY state or a HALT state.

While a reduced state is active, the block drives five clock-gating enables: oscillator, CPU, general peripherals, the free-running timer, and the serial receiver's start-bit detector. It also watches the wake sources that the current state qualifies. When one of them fires, the block returns to RUN and produces a one-cycle wake pulse. A 2-bit status output always reports the current state.

A build-time parameter can remove both low-power states permanently. With it cleared, the idle instruction only ever reaches IDLE.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode output is RUN (0), all five enables are 1 and the wake pulse is 0.
- R2: An idle pulse in RUN with the power-down bit at 0 moves the block to IDLE (mode 1) on the next cycle. In IDLE the CPU enable is 0 and the other four enables are 1.
- R3: An idle pulse in RUN with the power-down bit at 1 and the select bit at 0 moves the block to STANDBY (mode 2). In STANDBY the CPU and peripheral enables are 0, and the oscillator, timer and start-bit detector enables are 1.
- R4: An idle pulse in RUN with the power-down bit at 1 and the select bit at 1 moves the block to HALT (mode 3). In HALT all five enables are 0.
- R5: IDLE returns to RUN one cycle after any enabled external interrupt, an enabled timer interrupt, or the generic interrupt-pending input.
- R6: STANDBY returns to RUN on an enabled external interrupt, an enabled timer interrupt, or a qualified low level on the receive pin when its wake enable is set. The generic interrupt-pending input has no effect in STANDBY.
- R7: HALT returns to RUN only on an enabled external interrupt. The timer interrupt and the receive pin have no effect in HALT.
- R8: A wake source whose individual enable input is 0 does not end a reduced-activity state.
- R9: The receive pin passes through a two-flop synchronizer. A wake from it needs the synchronized line low on two consecutive clocks, so a low that starts before clock edge k gives RUN after edge k+3. A low lasting only one clock never wakes the block.
- R10: The wake output is high for exactly one cycle: the first cycle in RUN after any reduced state.
- R11: With the low-power parameter at 0, an idle pulse always leads to IDLE, whatever the two control bits say.
- R12: While a reduced state is active, changes to the control bits and further idle pulses have no effect on the mode.
- R13: Asserting reset in any state returns the block at once to RUN with all enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_exec | input | 1 | One-cycle pulse: idle instruction decoded |
| pd_req | input | 1 | Power-down request control bit |
| halt_sel | input | 1 | Selects HALT (1) or STANDBY (0) |
| ext_irq | input | N_EXT | External interrupt lines |
| ext_irq_en | input | N_EXT | Per-line wake enables |
| tmr_irq | input | 1 | Free-running timer interrupt |
| tmr_irq_en | input | 1 | Timer wake enable |
| irq_any | input | 1 | Any other enabled interrupt pending |
| rx_pin | input | 1 | Asynchronous serial receive line |
| rx_wake_en | input | 1 | Receive-low wake enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | General peripheral clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| rxdet_clk_en | output | 1 | Start-bit detector clock enable |
| mode | output | 2 | 0 RUN, 1 IDLE, 2 STANDBY, 3 HALT |
| wake | output | 1 | One-cycle pulse on return to RUN |

## Verification
The bench targets the sources each state has to ignore. These are the timer and the receive line in HALT, the generic interrupt in STANDBY, and any source whose enable is clear. A design that qualified sources with one shared mask would wake too early in those cases. It also sends a one-clock low on the receive line, which a design without the two-sample check would treat as a wake. It then times a real low to the exact cycle, so an extra or missing synchronizer stage shows up as a one-cycle shift. Finally it changes the control bits and repeats idle pulses while the block is asleep, and it builds a second instance with the low-power states removed. A design that re-sampled the bits, or that ignored the parameter, would show a wrong mode code.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_IDLE = 2'd1,
    M_STBY = 2'd2,
    M_HALT = 2'd3
  } lpm_mode_e;

  typedef struct packed {
    logic osc;
    logic cpu;
    logic periph;
    logic tmr;
    logic rxdet;
  } lpm_gate_t;
endpackage

// File: rtl/lpm_rx_filter.sv
module lpm_rx_filter #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  output logic rx_low
);
  logic [SYNC-1:0] sq;
  logic            prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq     <= '1;
      prev_q <= 1'b1;
    end else begin
      sq     <= {sq[SYNC-2:0], rx_pin};
      prev_q <= sq[SYNC-1];
    end
  end

  assign rx_low = ~sq[SYNC-1] & ~prev_q;

  // R9: a qualified low needs the synchronized line low on two consecutive cycles
  p_two_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_low |-> $past(~sq[SYNC-1]));
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
#(
  parameter int N_EXT = 3
) (
  input  lpm_mode_e        cur,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_irq_en,
  input  logic             tmr_irq,
  input  logic             tmr_irq_en,
  input  logic             irq_any,
  input  logic             rx_low,
  input  logic             rx_wake_en,
  output logic             wake_hit
);
  logic ext_hit, tmr_hit, rx_hit;

  assign ext_hit = |(ext_irq & ext_irq_en);
  assign tmr_hit = tmr_irq & tmr_irq_en;
  assign rx_hit  = rx_low & rx_wake_en;

  always_comb begin
    unique case (cur)
      M_IDLE:  wake_hit = ext_hit | tmr_hit | irq_any;
      M_STBY:  wake_hit = ext_hit | tmr_hit | rx_hit;
      M_HALT:  wake_hit = ext_hit;
      default: wake_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter bit LP_EN = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle_exec,
  input  logic      pd_req,
  input  logic      halt_sel,
  input  logic      wake_hit,
  output lpm_mode_e state,
  output logic      wake_q
);
  lpm_mode_e nxt;

  always_comb begin
    nxt = state;
    if (state == M_RUN) begin
      if (idle_exec) begin
        if (LP_EN && pd_req) nxt = halt_sel ? M_HALT : M_STBY;
        else                 nxt = M_IDLE;
      end
    end else if (wake_hit) begin
      nxt = M_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= M_RUN;
      wake_q <= 1'b0;
    end else begin
      state  <= nxt;
      wake_q <= (state != M_RUN) && wake_hit;
    end
  end

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_RUN && idle_exec) |=> state != M_RUN);

  p_wake_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (state == M_RUN && $past(state) != M_RUN));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state != M_RUN && !wake_hit) |=> state == $past(state));

  generate
    if (!LP_EN) begin : g_nolp
      p_no_lowpower_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_RUN || state == M_IDLE));
    end
  endgenerate
endmodule

// File: rtl/lpm_gate_dec.sv
module lpm_gate_dec
  import lpm_pkg::*;
(
  input  lpm_mode_e cur,
  output lpm_gate_t g
);
  always_comb begin
    g = '{osc: 1'b1, cpu: 1'b1, periph: 1'b1, tmr: 1'b1, rxdet: 1'b1};
    unique case (cur)
      M_IDLE: g.cpu = 1'b0;
      M_STBY: begin
        g.cpu    = 1'b0;
        g.periph = 1'b0;
      end
      M_HALT: g = '0;
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter bit LP_EN = 1'b1,
  parameter int N_EXT = 3,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_exec,
  input  logic             pd_req,
  input  logic             halt_sel,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_irq_en,
  input  logic             tmr_irq,
  input  logic             tmr_irq_en,
  input  logic             irq_any,
  input  logic             rx_pin,
  input  logic             rx_wake_en,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             tmr_clk_en,
  output logic             rxdet_clk_en,
  output logic [1:0]       mode,
  output logic             wake
);
  lpm_mode_e state;
  lpm_gate_t g;
  logic      rx_low, wake_hit;

  lpm_rx_filter #(.SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_low(rx_low));

  lpm_wake_qual #(.N_EXT(N_EXT)) u_wq (
    .cur(state), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
    .tmr_irq(tmr_irq), .tmr_irq_en(tmr_irq_en), .irq_any(irq_any),
    .rx_low(rx_low), .rx_wake_en(rx_wake_en), .wake_hit(wake_hit));

  lpm_fsm #(.LP_EN(LP_EN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .idle_exec(idle_exec), .pd_req(pd_req),
    .halt_sel(halt_sel), .wake_hit(wake_hit), .state(state), .wake_q(wake));

  lpm_gate_dec u_gd (.cur(state), .g(g));

  assign osc_en        = g.osc;
  assign cpu_clk_en    = g.cpu;
  assign periph_clk_en = g.periph;
  assign tmr_clk_en    = g.tmr;
  assign rxdet_clk_en  = g.rxdet;
  assign mode          = state;

  // R7: in HALT, timer and receive line must not wake the block
  p_halt_ext_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_HALT && !(|(ext_irq & ext_irq_en))) |=> mode == 2'd3);
endmodule

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_x = 0, pd = 0, hs = 0, tmr = 0, tmr_en = 0, irq_any = 0, rx = 1, rx_en = 0;
  logic [2:0] ext = '0, ext_en = '0;

  logic osc1, cpu1, per1, tm1, rd1, w1o;
  logic [1:0] md1;
  logic osc2, cpu2, per2, tm2, rd2, w2o;
  logic [1:0] md2;

  int n_chk = 0, n_fail = 0;
  logic [1:0] m1 = 0, m2 = 0;
  logic w1 = 0, w2 = 0, p1 = 1, p2 = 1, p3 = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .idle_exec(idle_x), .pd_req(pd), .halt_sel(hs),
    .ext_irq(ext), .ext_irq_en(ext_en), .tmr_irq(tmr), .tmr_irq_en(tmr_en),
    .irq_any(irq_any), .rx_pin(rx), .rx_wake_en(rx_en),
    .osc_en(osc1), .cpu_clk_en(cpu1), .periph_clk_en(per1), .tmr_clk_en(tm1),
    .rxdet_clk_en(rd1), .mode(md1), .wake(w1o));

  lpm_ctrl #(.LP_EN(1'b0)) dut_nolp (
    .clk(clk), .rst_n(rst_n), .idle_exec(idle_x), .pd_req(pd), .halt_sel(hs),
    .ext_irq(ext), .ext_irq_en(ext_en), .tmr_irq(tmr), .tmr_irq_en(tmr_en),
    .irq_any(irq_any), .rx_pin(rx), .rx_wake_en(rx_en),
    .osc_en(osc2), .cpu_clk_en(cpu2), .periph_clk_en(per2), .tmr_clk_en(tm2),
    .rxdet_clk_en(rd2), .mode(md2), .wake(w2o));

  function automatic logic [1:0] nxt(input logic [1:0] m, input bit lp, input logic q);
    logic eh;
    eh = |(ext & ext_en);
    case (m)
      2'd0: return idle_x ? ((lp && pd) ? (hs ? 2'd3 : 2'd2) : 2'd1) : 2'd0;
      2'd1: return (eh | (tmr & tmr_en) | irq_any) ? 2'd0 : 2'd1;
      2'd2: return (eh | (tmr & tmr_en) | (rx_en & q)) ? 2'd0 : 2'd2;
      default: return eh ? 2'd0 : 2'd3;
    endcase
  endfunction

  function automatic logic [7:0] exp_vec(input logic [1:0] m, input logic w);
    logic [4:0] g;
    case (m)
      2'd0: g = 5'b11111;
      2'd1: g = 5'b10111;
      2'd2: g = 5'b10011;
      default: g = 5'b00000;
    endcase
    return {m, g, w};
  endfunction

  task automatic model_reset();
    m1 = 0; m2 = 0; w1 = 0; w2 = 0; p1 = 1; p2 = 1; p3 = 1;
  endtask

  task automatic step();
    logic q;
    logic [1:0] n1, n2;
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      q  = ~p2 & ~p3;
      n1 = nxt(m1, 1'b1, q);
      n2 = nxt(m2, 1'b0, q);
      w1 = (m1 != 0) && (n1 == 0);
      w2 = (m2 != 0) && (n2 == 0);
      m1 = n1; m2 = n2;
      p3 = p2; p2 = p1; p1 = rx;
    end
    @(negedge clk);
  endtask

  task automatic chk(input string tag);
    logic [7:0] a1, a2, e1, e2;
    a1 = {md1, osc1, cpu1, per1, tm1, rd1, w1o};
    a2 = {md2, osc2, cpu2, per2, tm2, rd2, w2o};
    e1 = exp_vec(m1, w1);
    e2 = exp_vec(m2, w2);
    n_chk++;
    if (a1 !== e1) begin
      n_fail++;
      $display("FAIL %s: {mode,osc,cpu,per,tmr,rxdet,wake} got %b exp %b", tag, a1, e1);
    end
    n_chk++;
    if (a2 !== e2) begin
      n_fail++;
      $display("FAIL R11 (%s): no-low-power instance got %b exp %b", tag, a2, e2);
    end
  endtask

  task automatic clear_src();
    ext = '0; ext_en = '0; tmr = 0; tmr_en = 0; irq_any = 0; rx = 1; rx_en = 0; idle_x = 0;
  endtask

  task automatic enter(input logic p, input logic h, input string tag);
    pd = p; hs = h; idle_x = 1;
    step();
    idle_x = 0;
    chk(tag);
  endtask

  task automatic wake_all();
    clear_src(); ext = 3'b001; ext_en = 3'b001;
    step(); chk("R10");
    clear_src();
    step(); chk("R10");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int unsigned s;
    string tg;
    s = $urandom(32'h5EED_1234);
    @(negedge clk);
    chk("R1");
    step(); step();
    rst_n = 1;
    step(); chk("R1");

    // R2 / R5 / R10
    enter(0, 0, "R2");
    irq_any = 1; step(); chk("R5");
    irq_any = 0; step(); chk("R10");

    // R3 / R6 / R8
    enter(1, 0, "R3");
    irq_any = 1; step(); chk("R6");
    irq_any = 0; tmr = 1; step(); chk("R8");
    tmr_en = 1; step(); chk("R6");
    clear_src(); step(); chk("R10");

    // R4 / R7 / R8
    enter(1, 1, "R4");
    tmr = 1; tmr_en = 1; step(); chk("R7");
    rx = 0; rx_en = 1;
    for (int i = 0; i < 4; i++) begin step(); chk("R7"); end
    clear_src(); ext = 3'b010; step(); chk("R8");
    ext_en = 3'b010; step(); chk("R7");
    clear_src(); step(); chk("R10");

    // R9: glitch and exact latency
    enter(1, 0, "R3");
    rx_en = 1; rx = 0; step(); rx = 1;
    for (int i = 0; i < 5; i++) begin step(); chk("R9"); end
    rx = 0;
    for (int i = 0; i < 3; i++) begin step(); chk("R9"); end
    step(); chk("R9");
    clear_src(); step(); chk("R10");

    // R12: control bits and idle pulses while asleep
    enter(1, 0, "R3");
    pd = 0; hs = 1; idle_x = 1; step(); chk("R12");
    idle_x = 0; step(); chk("R12");
    wake_all();

    // R13: reset from HALT
    enter(1, 1, "R4");
    rst_n = 0; #1; model_reset(); chk("R13");
    step(); rst_n = 1; step(); chk("R13");

    // constrained random
    for (int i = 0; i < 250; i++) begin
      enter($urandom_range(0, 1), $urandom_range(0, 1), "R2");
      for (int k = 0; k < int'($urandom_range(1, 8)); k++) begin
        ext     = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b0;
        ext_en  = 3'($urandom);
        tmr     = ($urandom_range(0, 4) == 0);
        tmr_en  = $urandom_range(0, 1);
        irq_any = ($urandom_range(0, 5) == 0);
        rx      = ($urandom_range(0, 3) != 0) ? 1'b1 : 1'b0;
        rx_en   = $urandom_range(0, 1);
        step();
        case (m1)
          2'd1: tg = "R5";
          2'd2: tg = "R6";
          2'd3: tg = "R7";
          default: tg = "R10";
        endcase
        chk(tg);
      end
      wake_all();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule